// File: doc/BRIEF.md
# Programmable Interval Clock Interrupt

This block is a per-processor countdown timer that raises a periodic, sticky interrupt request. A host side writes a 32-bit interval value and issues three single-cycle commands: start periodic requests, stop them, and acknowledge the pending request. While running, a down-counter is loaded from the interval value, steps down by one each clock, and on reaching zero it raises the request flag and reloads. The request flag then stays set until the host acknowledges it.

Stopping the timer freezes the counter where it stands and blocks new requests until the next start. A request already pending is kept. An interval of zero gives the longest possible period instead of a request on every cycle. The outputs are the pending flag and the live count, so software and the bench can both see where the timer is.

Top module: `pit_clk_irq`

## Requirements
- R1: After reset the timer is stopped, the pending flag is 0 and the count output is 0.
- R2: A pulse on `intv_ld` captures `intv_wdata` as the new interval. It does not change the count on that cycle, whether the timer is running or stopped. The new value is used at the next reload.
- R3: A start pulse (`cmd_en`) loads the counter with the interval value, so the count output equals the interval one clock after the pulse.
- R4: While running, the count decreases by exactly one per clock until it reaches zero.
- R5: When the count is zero while running, the next clock sets the pending flag and reloads the counter from the interval. The request period is therefore interval+1 clocks.
- R6: The pending flag stays at 1 across reloads and further zero crossings until it is acknowledged.
- R7: An acknowledge pulse (`cmd_clr`) clears the pending flag on the next clock and does not disturb the countdown.
- R8: If an acknowledge coincides with a zero crossing, the flag stays set (the set wins).
- R9: A stop pulse (`cmd_dis`) freezes the count at its current value and blocks new requests until the next start. A pending flag is kept.
- R10: If start and stop arrive in the same cycle, the stop wins: the timer stays stopped and the count does not change.
- R11: An interval of 0 is treated as the maximum period: the counter loads all ones (0xFFFFFFFF) and counts down from there.
- R12: A start pulse while running restarts the countdown from the interval. A start pulse on a cycle where the count is zero reloads the counter without setting the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intv_ld | input | 1 | Interval write strobe |
| intv_wdata | input | 32 | Interval value to write |
| cmd_en | input | 1 | Start periodic requests (single-cycle pulse) |
| cmd_dis | input | 1 | Stop periodic requests (single-cycle pulse) |
| cmd_clr | input | 1 | Acknowledge the pending request (single-cycle pulse) |
| irq_pend | output | 1 | Sticky interrupt request |
| cnt_val | output | 32 | Current counter value |

## Verification
The assertions check the following on every clock:
- the counter steps down by one while running;
- it reloads from the interval at zero;
- it loads on a start pulse;
- it stays still while stopped;
- the flag is sticky;
- the set wins over a simultaneous acknowledge;
- the flag only rises after a running zero count.

The bench scenarios show the end-to-end behaviour that a one-cycle property cannot relate to the host's actions:
- the full interval+1 period;
- a new interval taking effect only at the next reload;
- a frozen count across a long stop;
- the start/stop tie;
- a restart in the middle of a period;
- the all-ones load for a zero interval.

// File: rtl/pit_pkg.sv
package pit_pkg;

  parameter int unsigned PIT_CNT_W = 32;

  // Per-cycle decisions made by the control unit
  typedef struct packed {
    logic load;   // load counter from reload value
    logic step;   // counter advances this cycle
    logic tick;   // zero crossing that raises a request
  } pit_ctl_t;

endpackage

// File: rtl/pit_intv_reg.sv
module pit_intv_reg
  import pit_pkg::*;
#(
  parameter int unsigned W = PIT_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] reload
);

  localparam logic [W-1:0] MAX_RELOAD = {W{1'b1}};

  logic [W-1:0] intv_q;
  logic [W-1:0] intv_d;

  always_comb begin
    intv_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intv_q <= '0;
    end else if (ld) begin
      intv_q <= intv_d;
    end
  end

  // A zero interval maps to the longest period
  always_comb begin
    if (intv_q == '0) reload = MAX_RELOAD;
    else              reload = intv_q;
  end

endmodule

// File: rtl/pit_ctl.sv
module pit_ctl
  import pit_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_en,
  input  logic     cmd_dis,
  input  logic     cnt_zero,
  output logic     run,
  output pit_ctl_t ctl
);

  logic run_q;
  logic run_d;
  logic run_ce;

  // Stop dominates start
  always_comb begin
    run_d  = run_q;
    run_ce = cmd_en | cmd_dis;
    if (cmd_dis)     run_d = 1'b0;
    else if (cmd_en) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (run_ce) begin
      run_q <= run_d;
    end
  end

  always_comb begin
    ctl.load = cmd_en & ~cmd_dis;
    ctl.step = run_q & ~cmd_en & ~cmd_dis;
    ctl.tick = run_q & ~cmd_en & ~cmd_dis & cnt_zero;
  end

  assign run = run_q;

endmodule

// File: rtl/pit_down_cnt.sv
module pit_down_cnt
  import pit_pkg::*;
#(
  parameter int unsigned W = PIT_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pit_ctl_t     ctl,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = ctl.load | ctl.step;
    cnt_d  = cnt_q;
    if (ctl.load) begin
      cnt_d = reload;
    end else if (ctl.step) begin
      if (cnt_q == '0) cnt_d = reload;
      else             cnt_d = cnt_q - {{(W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pit_pend.sv
module pit_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic pend
);

  logic pend_q;
  logic pend_d;
  logic pend_ce;

  // Set has priority over acknowledge
  always_comb begin
    pend_ce = tick | clr;
    pend_d  = pend_q;
    if (tick)     pend_d = 1'b1;
    else if (clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/pit_clk_irq.sv
module pit_clk_irq
  import pit_pkg::*;
#(
  parameter int unsigned W = PIT_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         intv_ld,
  input  logic [W-1:0] intv_wdata,
  input  logic         cmd_en,
  input  logic         cmd_dis,
  input  logic         cmd_clr,
  output logic         irq_pend,
  output logic [W-1:0] cnt_val
);

  logic [W-1:0] reload_val;
  logic         cnt_zero;
  logic         run_q;
  pit_ctl_t     ctl;

  pit_intv_reg #(.W(W)) u_intv (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (intv_ld),
    .wdata  (intv_wdata),
    .reload (reload_val)
  );

  pit_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_en   (cmd_en),
    .cmd_dis  (cmd_dis),
    .cnt_zero (cnt_zero),
    .run      (run_q),
    .ctl      (ctl)
  );

  pit_down_cnt #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .reload (reload_val),
    .cnt    (cnt_val),
    .zero   (cnt_zero)
  );

  pit_pend u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (ctl.tick),
    .clr   (cmd_clr),
    .pend  (irq_pend)
  );

endmodule

// File: rtl/pit_clk_irq_chk.sv
module pit_clk_irq_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_en,
  input logic         cmd_dis,
  input logic         cmd_clr,
  input logic         run,
  input logic [W-1:0] reload,
  input logic         irq_pend,
  input logic [W-1:0] cnt_val
);

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_dis) |=> (cnt_val == $past(reload)));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cmd_en && !cmd_dis && cnt_val != '0) |=>
      (cnt_val == $past(cnt_val) - W'(1)));

  // R5
  zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cmd_en && !cmd_dis && cnt_val == '0) |=>
      (cnt_val == $past(reload) && irq_pend));

  // R6
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !cmd_clr) |=> irq_pend);

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && !(run && !cmd_en && !cmd_dis && cnt_val == '0)) |=> !irq_pend);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && run && !cmd_en && !cmd_dis && cnt_val == '0) |=> irq_pend);

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!run && !cmd_en) || cmd_dis) |=> $stable(cnt_val));

  // R9
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(run && !cmd_en && !cmd_dis && cnt_val == '0));

  // R11
  reload_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload != '0);

endmodule

bind pit_clk_irq pit_clk_irq_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_en   (cmd_en),
  .cmd_dis  (cmd_dis),
  .cmd_clr  (cmd_clr),
  .run      (run_q),
  .reload   (reload_val),
  .irq_pend (irq_pend),
  .cnt_val  (cnt_val)
);

// File: tb/sim_pit_clk_irq.sv
`timescale 1ns/1ps
module sim_pit_clk_irq;

  logic        clk;
  logic        rst_n;
  logic        intv_ld;
  logic [31:0] intv_wdata;
  logic        cmd_en;
  logic        cmd_dis;
  logic        cmd_clr;
  logic        irq_pend;
  logic [31:0] cnt_val;

  int n_chk;
  int n_fail;
  bit done;

  pit_clk_irq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .intv_ld    (intv_ld),
    .intv_wdata (intv_wdata),
    .cmd_en     (cmd_en),
    .cmd_dis    (cmd_dis),
    .cmd_clr    (cmd_clr),
    .irq_pend   (irq_pend),
    .cnt_val    (cnt_val)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ld(input logic [31:0] v);
    intv_ld = 1'b1; intv_wdata = v;
    @(negedge clk);
    intv_ld = 1'b0;
  endtask

  task automatic pulse_cmd(input bit en, input bit dis, input bit clr);
    cmd_en = en; cmd_dis = dis; cmd_clr = clr;
    @(negedge clk);
    cmd_en = 1'b0; cmd_dis = 1'b0; cmd_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pend", {31'd0, irq_pend}, 32'd0);
    chk("R1 cnt", cnt_val, 32'd0);
  endtask

  task automatic t_load_idle;
    pulse_ld(32'd5);
    chk("R2 load leaves count", cnt_val, 32'd0);
    step(3);
    chk("R9 stopped stays frozen", cnt_val, 32'd0);
    chk("R9 no request while stopped", {31'd0, irq_pend}, 32'd0);
  endtask

  task automatic t_enable_period;
    pulse_cmd(1, 0, 0);
    chk("R3 start loads interval", cnt_val, 32'd5);
    for (int k = 1; k <= 5; k++) begin
      step(1);
      chk("R4 countdown", cnt_val, 32'(5 - k));
      chk("R4 no early request", {31'd0, irq_pend}, 32'd0);
    end
    step(1);
    chk("R5 reload at zero", cnt_val, 32'd5);
    chk("R5 request set", {31'd0, irq_pend}, 32'd1);
    step(6);
    chk("R5 period interval+1", cnt_val, 32'd5);
    chk("R6 request sticky", {31'd0, irq_pend}, 32'd1);
  endtask

  task automatic t_clear;
    step(2);
    chk("R4 before ack", cnt_val, 32'd3);
    pulse_cmd(0, 0, 1);
    chk("R7 ack clears", {31'd0, irq_pend}, 32'd0);
    chk("R7 countdown undisturbed", cnt_val, 32'd2);
  endtask

  task automatic t_clear_zero;
    step(2);
    chk("R8 at zero", cnt_val, 32'd0);
    pulse_cmd(0, 0, 1);
    chk("R8 set wins over ack", {31'd0, irq_pend}, 32'd1);
    chk("R8 reload", cnt_val, 32'd5);
  endtask

  task automatic t_disable;
    pulse_cmd(0, 0, 1);
    chk("R7 ack", {31'd0, irq_pend}, 32'd0);
    step(1);
    chk("R4 count", cnt_val, 32'd3);
    pulse_cmd(0, 1, 0);
    chk("R9 stop freezes", cnt_val, 32'd3);
    step(20);
    chk("R9 still frozen", cnt_val, 32'd3);
    chk("R9 requests blocked", {31'd0, irq_pend}, 32'd0);
    pulse_cmd(1, 0, 0);
    step(6);
    chk("R5 request again", {31'd0, irq_pend}, 32'd1);
    pulse_cmd(0, 1, 0);
    chk("R9 pending kept on stop", {31'd0, irq_pend}, 32'd1);
    chk("R9 frozen value", cnt_val, 32'd5);
    step(10);
    chk("R9 frozen after wait", cnt_val, 32'd5);
    chk("R9 pending kept", {31'd0, irq_pend}, 32'd1);
  endtask

  task automatic t_en_dis_same;
    pulse_cmd(1, 1, 0);
    chk("R10 tie count", cnt_val, 32'd5);
    step(3);
    chk("R10 stop wins", cnt_val, 32'd5);
  endtask

  task automatic t_restart;
    pulse_cmd(0, 0, 1);
    pulse_cmd(1, 0, 0);
    chk("R3 start", cnt_val, 32'd5);
    step(3);
    chk("R4 count", cnt_val, 32'd2);
    pulse_cmd(1, 0, 0);
    chk("R12 restart mid period", cnt_val, 32'd5);
    step(5);
    chk("R12 at zero", cnt_val, 32'd0);
    pulse_cmd(1, 0, 0);
    chk("R12 start at zero reloads", cnt_val, 32'd5);
    chk("R12 start at zero no request", {31'd0, irq_pend}, 32'd0);
  endtask

  task automatic t_ld_running;
    pulse_ld(32'd3);
    chk("R2 load while running", cnt_val, 32'd4);
    step(4);
    chk("R4 reached zero", cnt_val, 32'd0);
    step(1);
    chk("R2 new interval at reload", cnt_val, 32'd3);
    chk("R5 request", {31'd0, irq_pend}, 32'd1);
  endtask

  task automatic t_zero_intv;
    pulse_ld(32'd0);
    chk("R2 count", cnt_val, 32'd2);
    pulse_cmd(1, 0, 0);
    chk("R11 zero interval max", cnt_val, 32'hFFFF_FFFF);
    step(1);
    chk("R11 counts down", cnt_val, 32'hFFFF_FFFE);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; intv_ld = 1'b0; intv_wdata = '0;
    cmd_en = 1'b0; cmd_dis = 1'b0; cmd_clr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_load_idle();
    t_enable_period();
    t_clear();
    t_clear_zero();
    t_disable();
    t_en_dis_same();
    t_restart();
    t_ld_running();
    t_zero_intv();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule